// File: doc/BRIEF.md
# Nested Interrupt In-Service Tracker

This block records which interrupt priority levels a small controller core is servicing at any moment. It knows three levels. Power-fail is the highest, high is in the middle and low is the lowest. When the core takes a vector, the block receives a one-cycle strobe together with the level of the accepted interrupt, and it raises the flag for that level. When the core executes a return-from-interrupt, a one-cycle strobe lowers the flag of the highest level that is in service. Nested service therefore unwinds in order.

The three flags appear in the top three bits of a read-only status byte. The block also sends the interrupt arbiter a per-level hold mask. A level is held while any level at or above it is in service, so only a strictly higher request can interrupt the service in progress. A parameter removes the power-fail level on variants that have no such source. The flag is then tied to zero and power-fail strobes have no effect.

Top module: `isr_nest_tracker`

## Requirements
- R1: After reset, all eight bits of `status_o` are 0 and all three bits of `hold_o` are 0.
- R2: Level codes on `take_lvl_i` are 0 = low, 1 = high, 2 = power-fail. An accepted take sets the flag of its level in the cycle after the strobe. The flag positions in `status_o` are bit 5 for low, bit 6 for high and bit 7 for power-fail.
- R3: A take is accepted only if its level is strictly higher than every level in service. An accepted take keeps the flags that are already set, so low then high gives a status of 0x60.
- R4: A take whose level is at or below the highest level in service leaves `status_o` unchanged.
- R5: A return strobe clears only the highest flag that is set. The lower flags remain set.
- R6: A return strobe while no flag is set leaves `status_o` at 0.
- R7: `hold_o[k]` is 1 exactly when the flag of level k or of a higher level is set. The bit positions are 0 = low, 1 = high and 2 = power-fail.
- R8: A take with level code 3 is ignored.
- R9: With `HAS_PFAIL` = 0, bit 7 of `status_o` and `hold_o[2]` stay 0, and a power-fail take changes nothing.
- R10: Bits 4 to 0 of `status_o` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| take_i | input | 1 | Vector-taken strobe, one cycle wide |
| take_lvl_i | input | 2 | Level of the taken interrupt (0 low, 1 high, 2 power-fail) |
| reti_i | input | 1 | Return-from-interrupt strobe, one cycle wide |
| status_o | output | 8 | Status byte: in-service flags in bits 7..5, other bits 0 |
| hold_o | output | 3 | Per-level hold mask to the arbiter |

## Verification
A return and the next admission decision can fall in adjacent cycles. The clear from the return must reach the hold mask in time for the take that follows. The bench provokes this with low and high in service: a return is followed in the very next cycle by a high take, and the status must come back as 0x60. A take that meets an occupied level in the same cycle as that level's flag is being held is also driven. It is judged by the status byte staying unchanged. The same stimulus is applied to a second instance built without power-fail.

// File: rtl/isr_lvl_pkg.sv
package isr_lvl_pkg;
  localparam int NUM_LVL = 3;
  localparam int LVL_W   = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_LO   = 2'd0,
    LVL_HI   = 2'd1,
    LVL_PF   = 2'd2,
    LVL_NONE = 2'd3
  } lvl_e;
endpackage

// File: rtl/isr_admit.sv
module isr_admit
  import isr_lvl_pkg::*;
#(
  parameter bit HAS_PFAIL = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] flags_i,
  input  logic               take_i,
  input  logic [LVL_W-1:0]   take_lvl_i,
  output logic [NUM_LVL-1:0] hold_o,
  output logic [NUM_LVL-1:0] set_oh_o
);
  logic lvl_ok;

  always_comb begin
    lvl_ok = (take_lvl_i < LVL_W'(NUM_LVL));
    if (!HAS_PFAIL && take_lvl_i == LVL_PF) lvl_ok = 1'b0;
  end

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
    assign hold_o[k]   = |flags_i[NUM_LVL-1:k];
    assign set_oh_o[k] = take_i && lvl_ok && (take_lvl_i == LVL_W'(k)) && !hold_o[k];
    if (k > 0) begin : g_thermo
      // R7: hold mask is a thermometer from the top level down
      a_r7_hold_thermo: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o[k] |-> hold_o[k-1]);
    end
  end

  a_r8_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && take_lvl_i == LVL_NONE) |-> (set_oh_o == '0));
endmodule

// File: rtl/isr_flag_bank.sv
module isr_flag_bank
  import isr_lvl_pkg::*;
#(
  parameter bit HAS_PFAIL = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] set_oh_i,
  input  logic               reti_i,
  output logic [NUM_LVL-1:0] flags_o
);
  logic [NUM_LVL-1:0] flags_q;
  logic [NUM_LVL-1:0] flags_d;
  logic [NUM_LVL-1:0] top_oh;
  logic               any_set;
  logic               upd_en;

  assign any_set = |flags_q;

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_top
    if (k == NUM_LVL-1) begin : g_msb
      assign top_oh[k] = flags_q[k];
    end else begin : g_rest
      assign top_oh[k] = flags_q[k] && !(|flags_q[NUM_LVL-1:k+1]);
    end
  end

  always_comb begin
    flags_d = flags_q;
    upd_en  = 1'b0;
    if (|set_oh_i) begin
      flags_d = flags_q | set_oh_i;
      upd_en  = 1'b1;
    end else if (reti_i && any_set) begin
      flags_d = flags_q & ~top_oh;
      upd_en  = 1'b1;
    end
    if (!HAS_PFAIL) flags_d[LVL_PF] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (upd_en) begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

  // R3: an admitted take adds exactly one flag
  a_r3_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_oh_i) |=> ($countones(flags_q) == $countones($past(flags_q)) + 1));
  // R5: a return removes exactly one flag when any is set
  a_r5_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && any_set) |=> ($countones(flags_q) + 1 == $countones($past(flags_q))));
  // R6: a return with nothing in service leaves all flags clear
  a_r6_idle_reti: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !any_set && set_oh_i == '0) |=> (flags_q == '0));
  // R9: power-fail flag absent when the level is not built
  a_r9_no_pfail: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_PFAIL |-> !flags_q[LVL_PF]);
endmodule

// File: rtl/isr_status_pack.sv
module isr_status_pack
  import isr_lvl_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic [NUM_LVL-1:0] flags_i,
  output logic [STAT_W-1:0]  status_o
);
  localparam int BASE = STAT_W - NUM_LVL;

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (b >= BASE) begin : g_flag
      assign status_o[b] = flags_i[b-BASE];
    end else begin : g_zero
      assign status_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/isr_nest_tracker.sv
module isr_nest_tracker
  import isr_lvl_pkg::*;
#(
  parameter bit HAS_PFAIL = 1'b1,
  parameter int STAT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [1:0]        take_lvl_i,
  input  logic              reti_i,
  output logic [STAT_W-1:0] status_o,
  output logic [2:0]        hold_o
);
  localparam int BASE = STAT_W - NUM_LVL;

  logic [NUM_LVL-1:0] flags;
  logic [NUM_LVL-1:0] set_oh;
  logic [NUM_LVL-1:0] hold;

  isr_admit #(.HAS_PFAIL(HAS_PFAIL)) admit_i (
    .clk(clk), .rst_n(rst_n), .flags_i(flags), .take_i(take_i),
    .take_lvl_i(take_lvl_i), .hold_o(hold), .set_oh_o(set_oh)
  );

  isr_flag_bank #(.HAS_PFAIL(HAS_PFAIL)) bank_i (
    .clk(clk), .rst_n(rst_n), .set_oh_i(set_oh), .reti_i(reti_i),
    .flags_o(flags)
  );

  isr_status_pack #(.STAT_W(STAT_W)) pack_i (
    .flags_i(flags), .status_o(status_o)
  );

  assign hold_o = hold;

  // R4: a take at a held level leaves the status byte alone
  a_r4_held_take: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && take_lvl_i < 2'd3 && hold[take_lvl_i] && !reti_i) |=> $stable(status_o));
  // R10: low status bits stay zero
  a_r10_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[BASE-1:0] == '0);
  a_r2_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_i && reti_i));
endmodule

// File: tb/isr_nest_tracker_tb_top.sv
module isr_nest_tracker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       take_i;
  logic [1:0] take_lvl_i;
  logic       reti_i;
  logic [7:0] status_o, status_np;
  logic [2:0] hold_o, hold_np;
  int         n_chk;
  int         n_err;

  isr_nest_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .take_lvl_i(take_lvl_i),
    .reti_i(reti_i), .status_o(status_o), .hold_o(hold_o)
  );

  isr_nest_tracker #(.HAS_PFAIL(1'b0)) dut_np_i (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .take_lvl_i(take_lvl_i),
    .reti_i(reti_i), .status_o(status_np), .hold_o(hold_np)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic take(input logic [1:0] lvl);
    @(negedge clk); take_i = 1'b1; take_lvl_i = lvl;
    @(negedge clk); take_i = 1'b0; take_lvl_i = 2'd0;
  endtask

  task automatic reti();
    @(negedge clk); reti_i = 1'b1;
    @(negedge clk); reti_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 status", status_o, 8'h00);
    chk("R1 hold", {5'b0, hold_o}, 8'h00);
    chk("R1 np status", status_np, 8'h00);
  endtask

  task automatic t_single();
    take(2'd0);
    chk("R2 low set", status_o, 8'h20);
    chk("R7 hold low", {5'b0, hold_o}, 8'h01);
    chk("R10 low bits", {3'b0, status_o[4:0]}, 8'h00);
    reti();
    chk("R5 low cleared", status_o, 8'h00);
    take(2'd1);
    chk("R2 high set", status_o, 8'h40);
    reti();
    take(2'd2);
    chk("R2 pfail set", status_o, 8'h80);
    chk("R7 hold pfail", {5'b0, hold_o}, 8'h07);
    reti();
    chk("R5 pfail cleared", status_o, 8'h00);
  endtask

  task automatic t_nest();
    take(2'd0);
    take(2'd1);
    chk("R3 low+high", status_o, 8'h60);
    chk("R7 hold high", {5'b0, hold_o}, 8'h03);
    take(2'd2);
    chk("R3 all three", status_o, 8'hE0);
    reti();
    chk("R5 pfail first", status_o, 8'h60);
    reti();
    chk("R5 high next", status_o, 8'h20);
    reti();
    chk("R5 low last", status_o, 8'h00);
    chk("R7 hold idle", {5'b0, hold_o}, 8'h00);
  endtask

  task automatic t_block();
    take(2'd1);
    take(2'd0);
    chk("R4 low under high", status_o, 8'h40);
    take(2'd1);
    chk("R4 high under high", status_o, 8'h40);
    chk("R7 hold under high", {5'b0, hold_o}, 8'h03);
    take(2'd2);
    reti();
    reti();
    chk("R4 unwound", status_o, 8'h00);
  endtask

  task automatic t_idle_reti();
    reti();
    chk("R6 idle reti", status_o, 8'h00);
    reti();
    take(2'd0);
    chk("R6 take after idle reti", status_o, 8'h20);
    reti();
  endtask

  task automatic t_bad_code();
    take(2'd3);
    chk("R8 code 3", status_o, 8'h00);
    chk("R8 code 3 hold", {5'b0, hold_o}, 8'h00);
  endtask

  task automatic t_back_to_back();
    take(2'd0);
    take(2'd1);
    @(negedge clk); reti_i = 1'b1;
    @(negedge clk); reti_i = 1'b0; take_i = 1'b1; take_lvl_i = 2'd1;
    chk("R5 reti mid", status_o, 8'h20);
    @(negedge clk); take_i = 1'b0;
    chk("R3 retake after reti", status_o, 8'h60);
    reti();
    reti();
    chk("R5 back to back unwound", status_o, 8'h00);
  endtask

  task automatic t_no_pf();
    take(2'd2);
    chk("R9 np pfail ignored", status_np, 8'h00);
    chk("R9 np hold", {5'b0, hold_np}, 8'h00);
    reti();
    take(2'd0);
    take(2'd2);
    chk("R9 np low kept", status_np, 8'h20);
    chk("R9 np hold low", {5'b0, hold_np}, 8'h01);
    chk("R3 full pfail over low", status_o, 8'hA0);
    reti();
    reti();
    chk("R9 np unwound", status_np, 8'h00);
    chk("R5 full unwound", status_o, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_err = 0;
    rst_n = 1'b0;
    take_i = 1'b0;
    take_lvl_i = 2'd0;
    reti_i = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_nest();
    t_block();
    t_idle_reti();
    t_bad_code();
    t_back_to_back();
    t_no_pf();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule